// File: doc/BRIEF.md
# Three-Level Overcurrent Detector

This block watches discharge current while the pack is in normal mode. An analog front end supplies three level flags, one for each sense-voltage threshold: a light level (about 0.15 V across the discharge switch), a medium level (about 0.3 V) and a heavy level (about 1.0 V). A heavier level always implies the lighter ones. Each level has its own qualification timer, and heavier faults qualify sooner. The light level's delay comes in on a port, so the board can set it. The medium and heavy delays are fixed by parameters. With the default 10 us tick these give 4 ms and 300 us.

When any level has stayed high for its full delay, the block requests that discharge be switched off. It then holds that request for a minimum lockout, 25 600 ticks or 256 ms by default. After the lockout it waits for a load-released flag and only then returns to monitoring. A status field records which level caused the most recent trip. The protection sequencer drives a run enable, and when that enable is low (power-down) detection is suspended.

Top module: `ocp_guard`

## Requirements
- R1: After reset, `dsg_off` is 0, `lock_busy` is 0 and `trip_src` is 000.
- R2: The light level trips only after `lvl_lo` has been high for `lo_dly` consecutive ticks while monitoring. After `lo_dly`-1 ticks there is no trip.
- R3: The medium level trips after `lvl_mid` has been high for MID_TICKS ticks. After MID_TICKS-1 ticks there is no trip.
- R4: The heavy level trips after `lvl_hi` has been high for HI_TICKS ticks, which is less than MID_TICKS.
- R5: When a level flag drops before its delay expires, that level's tick count restarts from zero.
- R6: A trip raises `dsg_off` and `lock_busy`. `trip_src` becomes one-hot for the heaviest level that qualified: bit 0 light, bit 1 medium, bit 2 heavy.
- R7: After a trip, `lock_busy` and `dsg_off` stay high for exactly LOCK_TICKS ticks. `load_free` is ignored during that time.
- R8: After the lockout, `lock_busy` falls and `dsg_off` stays high until `load_free` is seen high. `dsg_off` falls one clock after that.
- R9: While `run_en` is low, no trip occurs and all level tick counts are held at zero.
- R10: While `dsg_off` is high, level flags do not change `trip_src`. It changes only at a new trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Normal-mode enable from the protection sequencer |
| tick | input | 1 | One-cycle time-base strobe (default 10 us) |
| lvl_lo | input | 1 | Light overcurrent level flag |
| lvl_mid | input | 1 | Medium overcurrent level flag |
| lvl_hi | input | 1 | Heavy overcurrent level flag |
| load_free | input | 1 | Load-released flag (pack terminals at high impedance) |
| lo_dly | input | LO_DLY_W | Light-level delay in ticks |
| dsg_off | output | 1 | Discharge-inhibit request |
| trip_src | output | 3 | One-hot cause of the last trip |
| lock_busy | output | 1 | Minimum lockout in progress |

## Verification
On every cycle the assertions check four things:
- `dsg_off` never falls before the lockout has counted its full number of ticks.
- `dsg_off` falls only after `load_free` has been seen.
- A trip happens only with `run_en` high, and always leaves a one-hot cause.
- `trip_src` never changes except when a trip begins.

Other behaviours need the bench's directed scenarios:
- the exact tick at which each level qualifies;
- the restart of a count after a flag glitch;
- the heaviest-level priority when flags overlap;
- the clearing of counts during power-down.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

   localparam int NLVL = 3;

   typedef enum logic [1:0] {
      ST_MON  = 2'd0,
      ST_LOCK = 2'd1,
      ST_WAIT = 2'd2
   } ocp_st_e;

   // heaviest qualified level wins; bit 2 heavy, bit 1 medium, bit 0 light
   function automatic logic [NLVL-1:0] pick_src(input logic [NLVL-1:0] q);
      if (q[2])      return 3'b100;
      else if (q[1]) return 3'b010;
      else           return 3'b001;
   endfunction

endpackage

// File: rtl/ocp_qual_timer.sv
module ocp_qual_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             tick,
   input  logic             flag,
   input  logic [CNT_W-1:0] limit,
   output logic             qual
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!arm || !flag)
         cnt <= '0;
      else if (tick && (cnt < limit))
         cnt <= cnt + 1'b1;
   end

   assign qual = arm && flag && (cnt >= limit);

endmodule

// File: rtl/ocp_trip_fsm.sv
module ocp_trip_fsm
   import ocp_pkg::*;
#(
   parameter int LOCK_TICKS = 25600
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            load_free,
   input  logic [NLVL-1:0] qual,
   output logic            mon_o,
   output logic            lock_o,
   output logic [NLVL-1:0] src_o
);

   localparam int LK_W = $clog2(LOCK_TICKS + 1);
   localparam logic [LK_W-1:0] LK_LAST = LK_W'(LOCK_TICKS - 1);

   ocp_st_e         st;
   logic [LK_W-1:0] lk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_MON;
         lk    <= '0;
         src_o <= '0;
      end else begin
         case (st)
            ST_MON: begin
               if (|qual) begin
                  st    <= ST_LOCK;
                  lk    <= '0;
                  src_o <= pick_src(qual);
               end
            end
            ST_LOCK: begin
               if (tick) begin
                  if (lk == LK_LAST) st <= ST_WAIT;
                  else               lk <= lk + 1'b1;
               end
            end
            ST_WAIT: begin
               if (load_free) st <= ST_MON;
            end
            default: st <= ST_MON;
         endcase
      end
   end

   assign mon_o  = (st == ST_MON);
   assign lock_o = (st == ST_LOCK);

endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
   import ocp_pkg::*;
#(
   parameter int LO_DLY_W   = 13,
   parameter int MID_TICKS  = 400,
   parameter int HI_TICKS   = 30,
   parameter int LOCK_TICKS = 25600
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run_en,
   input  logic                tick,
   input  logic                lvl_lo,
   input  logic                lvl_mid,
   input  logic                lvl_hi,
   input  logic                load_free,
   input  logic [LO_DLY_W-1:0] lo_dly,
   output logic                dsg_off,
   output logic [NLVL-1:0]     trip_src,
   output logic                lock_busy
);

   localparam int MID_W = $clog2(MID_TICKS + 1);
   localparam int CNT_W = (LO_DLY_W > MID_W) ? LO_DLY_W : MID_W;

   if (HI_TICKS < 1 || MID_TICKS <= HI_TICKS) begin : g_bad_delays
      $error("ocp_guard: need 1 <= HI_TICKS < MID_TICKS");
   end
   if (LOCK_TICKS < 1) begin : g_bad_lock
      $error("ocp_guard: LOCK_TICKS must be at least 1");
   end
   if (LO_DLY_W < 1) begin : g_bad_width
      $error("ocp_guard: LO_DLY_W must be at least 1");
   end

   logic [NLVL-1:0] lvl;
   logic [NLVL-1:0] qual;
   logic            mon;
   logic            arm;

   assign lvl = {lvl_hi, lvl_mid, lvl_lo};
   assign arm = mon && run_en;

   for (genvar gi = 0; gi < NLVL; gi++) begin : g_lvl
      logic [CNT_W-1:0] limit;
      if (gi == 0) begin : g_prog
         assign limit = CNT_W'(lo_dly);
      end else if (gi == 1) begin : g_mid
         assign limit = CNT_W'(MID_TICKS);
      end else begin : g_hi
         assign limit = CNT_W'(HI_TICKS);
      end

      ocp_qual_timer #(.CNT_W(CNT_W)) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .arm   (arm),
         .tick  (tick),
         .flag  (lvl[gi]),
         .limit (limit),
         .qual  (qual[gi])
      );
   end

   ocp_trip_fsm #(.LOCK_TICKS(LOCK_TICKS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .load_free (load_free),
      .qual      (qual),
      .mon_o     (mon),
      .lock_o    (lock_busy),
      .src_o     (trip_src)
   );

   assign dsg_off = !mon;

endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk #(
   parameter int LOCK_TICKS = 25600
) (
   input logic       clk,
   input logic       rst_n,
   input logic       run_en,
   input logic       tick,
   input logic       load_free,
   input logic       dsg_off,
   input logic [2:0] trip_src
);

   localparam int N_W = $clog2(LOCK_TICKS + 1);

   logic [N_W-1:0] held_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_ticks <= '0;
      else if (!dsg_off)
         held_ticks <= '0;
      else if (tick && (held_ticks != N_W'(LOCK_TICKS)))
         held_ticks <= held_ticks + 1'b1;
   end

   // R7
   lockout_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dsg_off) |-> (held_ticks >= N_W'(LOCK_TICKS)));

   // R8
   release_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dsg_off) |-> $past(load_free));

   // R6
   trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dsg_off) |-> ($countones(trip_src) == 1));

   // R9
   sleep_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !dsg_off) |=> !dsg_off);

   // R10
   cause_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(trip_src) |-> $rose(dsg_off));

endmodule

bind ocp_guard ocp_guard_chk #(.LOCK_TICKS(LOCK_TICKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .tick      (tick),
   .load_free (load_free),
   .dsg_off   (dsg_off),
   .trip_src  (trip_src)
);

// File: tb/tb_ocp_guard.sv
`timescale 1ns/1ps
module tb_ocp_guard;

   localparam int LO_DLY_W = 8;
   localparam int MID_T    = 8;
   localparam int HI_T     = 3;
   localparam int LOCK_T   = 20;
   localparam int LO_T     = 12;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                run_en = 1'b0;
   logic                tick = 1'b0;
   logic                lvl_lo = 1'b0;
   logic                lvl_mid = 1'b0;
   logic                lvl_hi = 1'b0;
   logic                load_free = 1'b0;
   logic [LO_DLY_W-1:0] lo_dly = LO_DLY_W'(LO_T);
   logic                dsg_off;
   logic [2:0]          trip_src;
   logic                lock_busy;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ocp_guard #(
      .LO_DLY_W(LO_DLY_W), .MID_TICKS(MID_T), .HI_TICKS(HI_T), .LOCK_TICKS(LOCK_T)
   ) dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
      .lvl_lo(lvl_lo), .lvl_mid(lvl_mid), .lvl_hi(lvl_hi),
      .load_free(load_free), .lo_dly(lo_dly),
      .dsg_off(dsg_off), .trip_src(trip_src), .lock_busy(lock_busy)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic flags(input logic h, input logic m, input logic l);
      @(negedge clk);
      lvl_hi = h; lvl_mid = m; lvl_lo = l;
   endtask

   task automatic release_all();
      flags(1'b0, 1'b0, 1'b0);
      load_free = 1'b1;
      ticks(LOCK_T);
      idle(2);
      chk("R8 release", int'(dsg_off), 0);
      load_free = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 dsg_off", int'(dsg_off), 0);
      chk("R1 lock_busy", int'(lock_busy), 0);
      chk("R1 trip_src", int'(trip_src), 0);
   endtask

   task automatic t_light();
      load_free = 1'b1;
      flags(1'b0, 1'b0, 1'b1);
      ticks(LO_T - 1); idle(2);
      chk("R2 no trip before delay", int'(dsg_off), 0);
      ticks(1); idle(1);
      chk("R2 trip at delay", int'(dsg_off), 1);
      chk("R6 lock_busy", int'(lock_busy), 1);
      chk("R6 trip_src light", int'(trip_src), 1);
      flags(1'b0, 1'b0, 1'b0);
      ticks(LOCK_T - 1); idle(1);
      chk("R7 still locked with load_free", int'(lock_busy), 1);
      chk("R7 still off", int'(dsg_off), 1);
      ticks(1);
      chk("R7 lockout ended", int'(lock_busy), 0);
      idle(1);
      chk("R8 released after load_free", int'(dsg_off), 0);
      load_free = 1'b0;
   endtask

   task automatic t_medium();
      flags(1'b0, 1'b1, 1'b1);
      ticks(MID_T - 1); idle(2);
      chk("R3 no trip before delay", int'(dsg_off), 0);
      ticks(1); idle(1);
      chk("R3 trip at delay", int'(dsg_off), 1);
      chk("R6 trip_src medium", int'(trip_src), 2);
      flags(1'b1, 1'b1, 1'b1);
      ticks(5); idle(2);
      chk("R10 cause held", int'(trip_src), 2);
      flags(1'b0, 1'b0, 1'b0);
      ticks(LOCK_T - 5); idle(3);
      chk("R8 lockout done", int'(lock_busy), 0);
      chk("R8 waits for load_free", int'(dsg_off), 1);
      load_free = 1'b1; idle(2);
      chk("R8 released", int'(dsg_off), 0);
      load_free = 1'b0;
   endtask

   task automatic t_heavy();
      flags(1'b1, 1'b1, 1'b1);
      ticks(HI_T - 1); idle(2);
      chk("R4 no trip before delay", int'(dsg_off), 0);
      ticks(1); idle(1);
      chk("R4 trip at delay", int'(dsg_off), 1);
      chk("R4 trip_src heavy", int'(trip_src), 4);
      release_all();
   endtask

   task automatic t_glitch();
      flags(1'b0, 1'b0, 1'b1);
      ticks(LO_T - 1);
      flags(1'b0, 1'b0, 1'b0);
      flags(1'b0, 1'b0, 1'b1);
      ticks(LO_T - 1); idle(2);
      chk("R5 count restarted", int'(dsg_off), 0);
      ticks(1); idle(1);
      chk("R5 trip after full delay", int'(dsg_off), 1);
      chk("R6 trip_src light", int'(trip_src), 1);
      release_all();
   endtask

   task automatic t_sleep();
      run_en = 1'b0;
      flags(1'b1, 1'b1, 1'b1);
      ticks(40); idle(2);
      chk("R9 no trip asleep", int'(dsg_off), 0);
      chk("R9 cause kept", int'(trip_src), 1);
      run_en = 1'b1;
      ticks(HI_T - 1); idle(2);
      chk("R9 counts cleared", int'(dsg_off), 0);
      ticks(1); idle(1);
      chk("R9 trip after wake", int'(dsg_off), 1);
      chk("R9 trip_src heavy", int'(trip_src), 4);
      release_all();
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R8 watchdog: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      run_en = 1'b1;
      t_light();
      t_medium();
      t_heavy();
      t_glitch();
      t_sleep();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule